// File: doc/BRIEF.md
# Profile-Based Quadrature Modulator Core

This block forms the digital core of a quadrature upconverter. Each system clock it takes one signed I sample and one signed Q sample that have already been interpolated. It rotates them onto a carrier produced by its own phase accumulator and emits one 12-bit signed result. Sine and cosine come from a quarter-wave table. Two multipliers and an add/subtract stage form I·cos(ωt) ± Q·sin(ωt). The sum is then rounded and clamped to the output width.

A small bank of four profiles shapes the carrier. Each profile holds a frequency step, the sign applied to the Q product, and a flag that turns the channel into a plain tone generator. In tone mode the output is the cosine of the running phase and the sample inputs are ignored. Two select pins pick the active profile on every clock. A simple write port loads one whole profile per write. Changing the selected profile never restarts the phase, so the carrier stays phase-continuous across frequency hops.

Top module: `qmod_core`

## Requirements
- R1: While `rst_n` is low, `mod_out` is 0, the phase is 0, and every profile holds step 0, sign subtract (`qneg`=1) and modulate mode (`tone`=0). The first three outputs after reset are 0.
- R2: On every rising clock edge the 32-bit phase increases by the step of the profile selected by `prof_sel` at that edge, wrapping modulo 2^32. The table address is phase bits 31:22.
- R3: For a 10-bit address a, the sine value is round(2047·sin(2π(a+0.5)/1024)), with ties rounded away from zero. The cosine value is the sine value at (a+256) mod 1024.
- R4: In modulate mode the output is clamp((S + 1024) >>> 11), where S = I·cos + Q·sin when the profile has `qneg`=0 and S = I·cos − Q·sin when it has `qneg`=1.
- R5: Results above 2047 come out as 2047, and results below −2048 come out as −2048.
- R6: In tone mode (`tone`=1) the output equals the cosine value of the phase, and `i_smp` and `q_smp` have no effect.
- R7: The samples, phase and profile fields sampled together at rising edge n appear on `mod_out` after edge n+2 and not before.
- R8: Switching `prof_sel` never resets or jumps the phase. The new step applies from the edge at which the new select is sampled.
- R9: A write (`wr_en`=1) at an edge replaces all three fields of profile `wr_prof`. Those fields take effect from the next edge, and the other profiles are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prof_sel | input | 2 | Active profile select |
| i_smp | input | 12 | In-phase sample, two's complement |
| q_smp | input | 12 | Quadrature sample, two's complement |
| wr_en | input | 1 | Profile write strobe |
| wr_prof | input | 2 | Profile written |
| wr_ftw | input | 32 | Phase step written |
| wr_qneg | input | 1 | 1 = subtract the Q product, 0 = add it |
| wr_tone | input | 1 | 1 = tone mode, 0 = modulate |
| mod_out | output | 12 | Modulated or tone output, two's complement |

## Verification
The hardest state to reach from the ports is a known, fixed carrier phase, because the phase has no load input and can only be steered through profile steps. The bench parks the phase at exact points by choosing a profile with a power-of-two step for a counted number of edges and then switching to a zero-step profile. This exposes saturation at the 45-degree point, the three-edge latency, and phase continuity across a hop. A one-address-per-clock tone sweep covers every table entry and every quadrant fold.

// File: rtl/qmod_pkg.sv
package qmod_pkg;
  localparam int unsigned QM_DW    = 12;
  localparam int unsigned QM_PW    = 32;
  localparam int unsigned QM_AW    = 10;
  localparam int unsigned QM_NPROF = 4;

  typedef enum logic {
    Q_ADD = 1'b0,
    Q_SUB = 1'b1
  } qsign_e;
endpackage

// File: rtl/qmod_prof_regs.sv
module qmod_prof_regs
  import qmod_pkg::*;
#(
  parameter int unsigned NPROF = QM_NPROF,
  parameter int unsigned PW    = QM_PW,
  localparam int unsigned SW   = $clog2(NPROF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [PW-1:0] wr_ftw,
  input  qsign_e        wr_sign,
  input  logic          wr_tone,
  input  logic [SW-1:0] rd_sel,
  output logic [PW-1:0] rd_ftw,
  output qsign_e        rd_sign,
  output logic          rd_tone
);
  logic [PW-1:0] ftw_arr  [NPROF];
  qsign_e        sign_arr [NPROF];
  logic          tone_arr [NPROF];

  for (genvar k = 0; k < NPROF; k++) begin : g_prof
    logic          en;
    logic [PW-1:0] ftw_d, ftw_q;
    qsign_e        sign_d, sign_q;
    logic          tone_d, tone_q;

    always_comb begin
      en     = wr_en && (wr_sel == SW'(k));
      ftw_d  = en ? wr_ftw  : ftw_q;
      sign_d = en ? wr_sign : sign_q;
      tone_d = en ? wr_tone : tone_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ftw_q  <= '0;
        sign_q <= Q_SUB;
        tone_q <= 1'b0;
      end else begin
        ftw_q  <= ftw_d;
        sign_q <= sign_d;
        tone_q <= tone_d;
      end
    end

    assign ftw_arr[k]  = ftw_q;
    assign sign_arr[k] = sign_q;
    assign tone_arr[k] = tone_q;
  end

  assign rd_ftw  = ftw_arr[rd_sel];
  assign rd_sign = sign_arr[rd_sel];
  assign rd_tone = tone_arr[rd_sel];
endmodule

// File: rtl/qmod_phase_acc.sv
module qmod_phase_acc #(
  parameter int unsigned PW = qmod_pkg::QM_PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] step,
  output logic [PW-1:0] phase
);
  logic [PW-1:0] acc_d, acc_q;

  always_comb acc_d = acc_q + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign phase = acc_q;
endmodule

// File: rtl/qmod_sincos.sv
module qmod_sincos #(
  parameter int unsigned AW = qmod_pkg::QM_AW,
  parameter int unsigned DW = qmod_pkg::QM_DW
) (
  input  logic [AW-1:0]        addr,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  localparam int unsigned QN  = 2 ** (AW - 2);
  localparam int          AMP = 2 ** (DW - 1) - 1;
  localparam real         TWO_PI = 6.283185307179586;

  logic signed [DW-1:0] qtab [QN];

  // Quarter wave sampled at half-step offsets so the fold is exactly symmetric
  for (genvar k = 0; k < QN; k++) begin : g_tab
    localparam real ANG = TWO_PI * (real'(k) + 0.5) / real'(4 * QN);
    localparam int  VAL = int'(real'(AMP) * $sin(ANG));
    assign qtab[k] = VAL[DW-1:0];
  end

  logic [1:0]           quad_s, quad_c;
  logic [AW-3:0]        idx, mir_s, mir_c;
  logic signed [DW-1:0] mag_s, mag_c;

  always_comb begin
    quad_s = addr[AW-1 -: 2];
    quad_c = quad_s + 2'd1;
    idx    = addr[AW-3:0];
    mir_s  = quad_s[0] ? ~idx : idx;
    mir_c  = quad_c[0] ? ~idx : idx;
    mag_s  = qtab[mir_s];
    mag_c  = qtab[mir_c];
    sin_o  = quad_s[1] ? -mag_s : mag_s;
    cos_o  = quad_c[1] ? -mag_c : mag_c;
  end
endmodule

// File: rtl/qmod_mixer.sv
module qmod_mixer
  import qmod_pkg::*;
#(
  parameter int unsigned DW = QM_DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  input  logic signed [DW-1:0] cos_in,
  input  logic signed [DW-1:0] sin_in,
  input  qsign_e               sign_in,
  input  logic                 tone_in,
  output logic signed [DW-1:0] y_out
);
  localparam int unsigned PRW  = 2 * DW;
  localparam int unsigned SUMW = PRW + 1;
  localparam int unsigned FRAC = DW - 1;
  localparam int          MAXI = 2 ** (DW - 1) - 1;

  // stage 1: capture
  logic signed [DW-1:0] s1_i, s1_q, s1_c, s1_s;
  qsign_e               s1_sign;
  logic                 s1_tone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_i    <= '0;
      s1_q    <= '0;
      s1_c    <= '0;
      s1_s    <= '0;
      s1_sign <= Q_SUB;
      s1_tone <= 1'b0;
    end else begin
      s1_i    <= i_in;
      s1_q    <= q_in;
      s1_c    <= cos_in;
      s1_s    <= sin_in;
      s1_sign <= sign_in;
      s1_tone <= tone_in;
    end
  end

  // stage 2: products
  logic signed [PRW-1:0] ext_i, ext_q, ext_c, ext_s, pq;
  logic signed [PRW-1:0] pi_d, pq_d, pi_q, pq_q;

  always_comb begin
    ext_i = {{DW{s1_i[DW-1]}}, s1_i};
    ext_q = {{DW{s1_q[DW-1]}}, s1_q};
    ext_c = {{DW{s1_c[DW-1]}}, s1_c};
    ext_s = {{DW{s1_s[DW-1]}}, s1_s};
    pq    = ext_q * ext_s;
    if (s1_tone) begin
      pi_d = ext_c <<< FRAC;
      pq_d = '0;
    end else begin
      pi_d = ext_i * ext_c;
      pq_d = (s1_sign == Q_SUB) ? -pq : pq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi_q <= '0;
      pq_q <= '0;
    end else begin
      pi_q <= pi_d;
      pq_q <= pq_d;
    end
  end

  // stage 3: sum, round, clamp
  logic signed [SUMW-1:0] sum, rnd, shf;
  logic signed [DW-1:0]   y_d, y_q;

  always_comb begin
    sum = {pi_q[PRW-1], pi_q} + {pq_q[PRW-1], pq_q};
    rnd = sum + SUMW'(2 ** (FRAC - 1));
    shf = rnd >>> FRAC;
    if (shf > SUMW'(MAXI))          y_d = DW'(MAXI);
    else if (shf < SUMW'(-MAXI - 1)) y_d = DW'(-MAXI - 1);
    else                            y_d = shf[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= y_d;
  end

  assign y_out = y_q;
endmodule

// File: rtl/qmod_core.sv
module qmod_core
  import qmod_pkg::*;
#(
  parameter int unsigned NPROF = QM_NPROF,
  parameter int unsigned PW    = QM_PW,
  parameter int unsigned AW    = QM_AW,
  parameter int unsigned DW    = QM_DW,
  localparam int unsigned SW   = $clog2(NPROF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] prof_sel,
  input  logic [DW-1:0] i_smp,
  input  logic [DW-1:0] q_smp,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_prof,
  input  logic [PW-1:0] wr_ftw,
  input  logic          wr_qneg,
  input  logic          wr_tone,
  output logic [DW-1:0] mod_out
);
  logic [PW-1:0]        cur_ftw;
  qsign_e               cur_sign;
  logic                 cur_tone;
  logic [PW-1:0]        phase_q;
  logic signed [DW-1:0] sin_w, cos_w, y_w;

  qmod_prof_regs #(.NPROF(NPROF), .PW(PW)) u_prof (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_prof),
    .wr_ftw  (wr_ftw),
    .wr_sign (qsign_e'(wr_qneg)),
    .wr_tone (wr_tone),
    .rd_sel  (prof_sel),
    .rd_ftw  (cur_ftw),
    .rd_sign (cur_sign),
    .rd_tone (cur_tone)
  );

  qmod_phase_acc #(.PW(PW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (cur_ftw),
    .phase (phase_q)
  );

  qmod_sincos #(.AW(AW), .DW(DW)) u_lut (
    .addr  (phase_q[PW-1 -: AW]),
    .sin_o (sin_w),
    .cos_o (cos_w)
  );

  qmod_mixer #(.DW(DW)) u_mix (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_in    ($signed(i_smp)),
    .q_in    ($signed(q_smp)),
    .cos_in  (cos_w),
    .sin_in  (sin_w),
    .sign_in (cur_sign),
    .tone_in (cur_tone),
    .y_out   (y_w)
  );

  assign mod_out = y_w;
endmodule

// File: rtl/qmod_chk.sv
module qmod_chk #(
  parameter int unsigned DW = qmod_pkg::QM_DW,
  parameter int unsigned PW = qmod_pkg::QM_PW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] i_smp,
  input logic [DW-1:0] q_smp,
  input logic [DW-1:0] mod_out,
  input logic [PW-1:0] phase,
  input logic [PW-1:0] cur_ftw,
  input logic          cur_tone,
  input logic [DW-1:0] cos_w
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1: pipeline is flushed to zero for the first outputs after reset
  a_r1_pipe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd3) |-> (mod_out == '0));

  // R2: a nonzero step always moves the phase
  a_r2_phase_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ftw != '0) |=> !$stable(phase));

  // R8: a zero step holds the phase where it is
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ftw == '0) |=> $stable(phase));

  // R6: tone output is the table cosine three edges later
  a_r6_tone_cos: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(cur_tone, 3)) |-> (mod_out == $past(cos_w, 3)));

  // R4: zero samples in modulate mode give zero out
  a_r4_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(!cur_tone && i_smp == '0 && q_smp == '0, 3))
      |-> (mod_out == '0));
endmodule

bind qmod_core qmod_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .i_smp    (i_smp),
  .q_smp    (q_smp),
  .mod_out  (mod_out),
  .phase    (phase_q),
  .cur_ftw  (cur_ftw),
  .cur_tone (cur_tone),
  .cos_w    (cos_w)
);

// File: tb/sim_qmod_core.sv
module sim_qmod_core;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  prof_sel;
  logic [11:0] i_smp, q_smp;
  logic        wr_en;
  logic [1:0]  wr_prof;
  logic [31:0] wr_ftw;
  logic        wr_qneg, wr_tone;
  logic [11:0] mod_out;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qmod_core u0 (
    .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .i_smp(i_smp), .q_smp(q_smp),
    .wr_en(wr_en), .wr_prof(wr_prof), .wr_ftw(wr_ftw), .wr_qneg(wr_qneg),
    .wr_tone(wr_tone), .mod_out(mod_out)
  );

  // ---------- reference model built from the requirements ----------
  function automatic int tsin(int a);
    real r;
    r = 2047.0 * $sin(6.283185307179586 * (real'(a) + 0.5) / 1024.0);
    return int'(r);
  endfunction

  function automatic int expect_val(logic [11:0] iv, logic [11:0] qv,
                                    logic [31:0] acc, bit neg, bit tone);
    int a, c, s, sum, r;
    a = int'(acc[31:22]);
    c = tsin((a + 256) % 1024);
    s = tsin(a);
    if (tone) sum = c * 2048;
    else sum = int'($signed(iv)) * c +
               (neg ? -(int'($signed(qv)) * s) : int'($signed(qv)) * s);
    r = (sum + 1024) >>> 11;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  logic [31:0] m_ftw [4];
  bit          m_neg [4];
  bit          m_tone[4];
  logic [31:0] m_acc;
  int          e_a, e_b, e_c;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_ftw[k] <= '0; m_neg[k] <= 1'b1; m_tone[k] <= 1'b0;
      end
      m_acc <= '0; e_a <= 0; e_b <= 0; e_c <= 0;
    end else begin
      e_a   <= expect_val(i_smp, q_smp, m_acc, m_neg[prof_sel], m_tone[prof_sel]);
      e_b   <= e_a;
      e_c   <= e_b;
      m_acc <= m_acc + m_ftw[prof_sel];
      if (wr_en) begin
        m_ftw[wr_prof]  <= wr_ftw;
        m_neg[wr_prof]  <= wr_qneg;
        m_tone[wr_prof] <= wr_tone;
      end
    end
  end

  // ---------- helpers ----------
  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outv();
    return int'($signed(mod_out));
  endfunction

  task automatic wr(logic [1:0] p, logic [31:0] f, bit neg, bit tone);
    @(negedge clk);
    wr_en = 1'b1; wr_prof = p; wr_ftw = f; wr_qneg = neg; wr_tone = tone;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset output", outv(), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // ---------- vector table: {sel, i, q, hold} ----------
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 12'd1000, 12'd500,  8'd4},   // R4 default subtract
    {2'd1, 12'd1500, 12'hC00,  8'd5},   // R4 add, negative Q
    {2'd1, 12'h800,  12'h7FF,  8'd9},   // R2 running phase
    {2'd2, 12'd300,  12'hF00,  8'd6},   // R2 backward wrap
    {2'd3, 12'd1234, 12'd77,   8'd5},   // R6 tone
    {2'd1, 12'd2047, 12'd2047, 8'd7},   // R8 hop back, phase continuous
    {2'd0, 12'hA00,  12'd5,    8'd3},   // R9 rewritten profile
    {2'd2, 12'h7FF,  12'h800,  8'd4}    // R5 range
  };
  localparam string VTAG [NV] = '{"R4", "R4", "R2", "R2", "R6", "R8", "R9", "R5"};

  int c384, v500;

  initial begin
    rst_n = 1'b1; prof_sel = '0; i_smp = '0; q_smp = '0;
    wr_en = 1'b0; wr_prof = '0; wr_ftw = '0; wr_qneg = 1'b0; wr_tone = 1'b0;
    do_reset();

    // R1: default profile subtracts the Q product; phase 0 gives 998
    @(negedge clk); i_smp = 12'd1000; q_smp = 12'd500;
    repeat (4) @(negedge clk);
    chk("R1 default subtract", outv(), 998);

    // table walk against the model
    wr(2'd1, 32'h0123_4567, 1'b0, 1'b0);
    wr(2'd2, 32'hFFFF_F000, 1'b1, 1'b0);
    wr(2'd3, 32'h0098_7654, 1'b0, 1'b1);
    for (int v = 0; v < NV; v++) begin
      if (v == 6) wr(2'd0, 32'h0031_0000, 1'b0, 1'b0);  // R9 rewrite p0
      @(negedge clk);
      prof_sel = VEC[v][33:32]; i_smp = VEC[v][31:20]; q_smp = VEC[v][19:8];
      repeat (int'(VEC[v][7:0])) @(negedge clk);
      chk(VTAG[v], outv(), e_c);
    end

    // directed: park phase at address 128 (45 degrees)
    do_reset();
    wr(2'd0, 32'h0, 1'b0, 1'b0);
    wr(2'd1, 32'h0800_0000, 1'b0, 1'b0);
    wr(2'd2, 32'h0, 1'b1, 1'b1);
    @(negedge clk); prof_sel = 2'd1;
    repeat (4) @(negedge clk);
    prof_sel = 2'd0; i_smp = 12'd2047; q_smp = 12'd2047;
    repeat (4) @(negedge clk);
    chk("R5 positive clamp", outv(), 2047);
    i_smp = 12'h800; q_smp = 12'h800;
    repeat (4) @(negedge clk);
    chk("R5 negative clamp", outv(), -2048);

    // R7: latency of three edges
    i_smp = '0; q_smp = '0;
    repeat (4) @(negedge clk);
    chk("R7 settled zero", outv(), 0);
    c384 = tsin(384);
    v500 = (500 * c384 + 1024) >>> 11;
    i_smp = 12'd500;
    @(negedge clk); chk("R7 edge one", outv(), 0);
    @(negedge clk); chk("R7 edge two", outv(), 0);
    @(negedge clk); chk("R7 edge three", outv(), v500);

    // R8: hop 2 edges at step 2^27, then tone with zero step -> address 192
    prof_sel = 2'd1;
    repeat (2) @(negedge clk);
    prof_sel = 2'd2;
    repeat (4) @(negedge clk);
    chk("R8 continuous phase", outv(), tsin(448));

    // R6: sample inputs ignored in tone mode
    for (int k = 0; k < 4; k++) begin
      i_smp = 12'(k * 613 + 7); q_smp = 12'(12'hFFF - k * 401);
      @(negedge clk);
      chk("R6 inputs ignored", outv(), tsin(448));
    end

    // R3: full table sweep, one address per clock
    wr(2'd3, 32'h0040_0000, 1'b0, 1'b1);
    @(negedge clk); prof_sel = 2'd3;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 1030; k++) begin
      chk("R3 table sweep", outv(), e_c);
      @(negedge clk);
    end

    // R1: reset during activity clears output at once
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", outv(), 0);
    @(negedge clk); rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule